// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies datums from one memory-mapped region to another over a plain request/grant memory port. Software writes 16-byte descriptors into memory and points the channel at the first one. Each descriptor holds a control word, the address of the last source datum, the address of the last destination datum, and a link to the next descriptor. The engine fetches the descriptor and works out each start address backwards from the stored end address. It then moves the datums one at a time, each as a read followed by a write.

A side can wrap its address inside a burst window of 2^N datums. The window size and the two wrap enables come from a channel setting that stays stable for the whole run. At the end of a descriptor the channel raises its completion flags. If the descriptor asks for a reload and its link is non-null, the channel fetches the linked descriptor and carries on without software help. A descriptor that is not marked valid holds the channel until software sets the valid bit. A transfer also waits until a trigger is pending.

Top module: `lkd_dma_chan`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `flag_a_o`, `flag_b_o`, `err_o` and `mem_req_o` are all low.
- R2: A descriptor is four 32-bit little-endian words at pointer +0, +4, +8 and +12. The words are, in that order: control, source end address, destination end address, next link. A pulse on `start_i` in idle makes the channel fetch a descriptor from `start_ptr_i`.
- R3: Control word fields: bit 0 valid, bit 1 reload, bit 2 software trigger, bit 3 clear trigger at end, bit 4 set flag A, bit 5 set flag B, bits 9:8 width code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), bits 13:12 source increment, bits 15:14 destination increment, bits 25:16 count minus one (up to 1024 datums).
- R4: Without wrap, a side visits ascending addresses from start = end − width × (count − 1) × stride to the stored end. Increment code 0 keeps the address fixed. Codes 1, 2 and 3 use a stride of 1, 2 or 4 times the width.
- R5: With wrap enabled for a side (`ch_src_wrap_i` or `ch_dst_wrap_i`), the stored end is the last address of a window of 2^`ch_burst_log2_i` datums. The address returns to the window start after every such burst.
- R6: Each datum is a read of the source address followed by a write of the destination address. `mem_size_o` carries the width code, and data sits in the low bytes of the 32-bit buses.
- R7: A descriptor with the valid bit clear holds the channel busy, with no memory access, until a `set_valid_i` pulse.
- R8: Data moves only while a trigger is pending. A trigger is set by control bit 2 at load or by a `trig_i` pulse while the channel is busy. Control bit 3 clears it at the end of the descriptor.
- R9: At the end of a descriptor, `flag_a_o` and `flag_b_o` are set if control bits 4 and 5 ask for them. Both flags stay set until the next accepted `start_i`.
- R10: At the end of a descriptor whose reload bit is set and whose link is non-null, the channel fetches the linked descriptor and runs it, subject to R7 and R8. With the reload bit clear, the channel goes idle.
- R11: A source or destination end address not aligned to the width, or width code 3, sets `err_o` and returns the channel to idle with no data moved. `err_o` stays set until the next accepted `start_i`.
- R12: `busy_o` rises in the cycle after `start_i` is accepted. It falls in the cycle after the last write of a non-reloading descriptor is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the channel from a descriptor pointer (idle only) |
| start_ptr_i | input | ADDR_W | Address of the first descriptor |
| set_valid_i | input | 1 | Set the valid bit of a stalled descriptor |
| trig_i | input | 1 | Hardware trigger pulse |
| ch_burst_log2_i | input | BURST_W | Burst window size as a power of two |
| ch_src_wrap_i | input | 1 | Source burst-window wrap enable |
| ch_dst_wrap_i | input | 1 | Destination burst-window wrap enable |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_size_o | output | 2 | Width code of the access |
| mem_wdata_o | output | 32 | Write data, low bytes used |
| mem_gnt_i | input | 1 | Access accepted this cycle; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Channel active |
| flag_a_o | output | 1 | Sticky completion flag A |
| flag_b_o | output | 1 | Sticky completion flag B |
| err_o | output | 1 | Sticky alignment or width error |

## Verification
The bench builds the channel with its default 32-bit address and 4-bit burst exponent. Its memory model decodes 1 KiB and grants about three requests in four, so every fetch, read and write sees stall cycles. The burst setting is changed between runs to windows of 2 and 4 datums, which makes source replay and destination overwrite show up in a few beats. Transfer lengths stay short, so all three widths, all increment codes, wrap, reload chains and the stall and trigger holds can be covered within a small window of cycles.

// File: rtl/lkd_dma_pkg.sv
`timescale 1ns/1ps
package lkd_dma_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 10;
  localparam int B_VALID  = 0;
  localparam int B_RELOAD = 1;
  localparam int B_SWTRIG = 2;
  localparam int B_CLRTRG = 3;
  localparam int B_FLAGA  = 4;
  localparam int B_FLAGB  = 5;
  localparam int W_LO     = 8;
  localparam int SINC_LO  = 12;
  localparam int DINC_LO  = 14;
  localparam int CNT_LO   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_PREP, ST_STALL, ST_ARM, ST_RD, ST_WR
  } lkd_state_e;
endpackage

// File: rtl/lkd_beat_cnt.sv
`timescale 1ns/1ps
module lkd_beat_cnt #(
  parameter int CNT_W   = 10,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [CNT_W-1:0]   last_m1_i,
  input  logic [BURST_W-1:0] burst_log2_i,
  output logic               is_last_o,
  output logic               burst_end_o
);
  logic [CNT_W-1:0] idx_q, idx_d, mask;

  always_comb begin
    if (int'(burst_log2_i) >= CNT_W) mask = '1;
    else                             mask = CNT_W'((32'd1 << burst_log2_i) - 32'd1);
  end

  assign is_last_o   = (idx_q == last_m1_i);
  assign burst_end_o = ((idx_q & mask) == mask);

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (inc_i) idx_d = idx_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (clr_i || inc_i)   idx_q <= idx_d;
  end

  // R3: a beat is never taken past the programmed count
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> (idx_q <= last_m1_i));
endmodule

// File: rtl/lkd_addr_gen.sv
`timescale 1ns/1ps
module lkd_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 10,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               wrap_pt_i,
  input  logic [ADDR_W-1:0]  end_i,
  input  logic [1:0]         inc_i,
  input  logic [1:0]         wcode_i,
  input  logic               wrap_en_i,
  input  logic [BURST_W-1:0] burst_log2_i,
  input  logic [CNT_W-1:0]   cnt_m1_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               misalign_o
);
  logic [2:0]        shamt;
  logic [ADDR_W-1:0] span_m1, span_off, step_c, start_c;
  logic [ADDR_W-1:0] start_q, addr_q, step_q, end_q;
  logic [ADDR_W-1:0] start_d, addr_d, step_d, end_d;
  logic              wrap_q, wrap_d;

  always_comb begin
    shamt   = {1'b0, wcode_i} + {1'b0, inc_i} - 3'd1;
    span_m1 = wrap_en_i ? ((ADDR_W'(1) << burst_log2_i) - ADDR_W'(1))
                        : ADDR_W'(cnt_m1_i);
    if (inc_i == 2'd0) begin
      step_c   = '0;
      span_off = '0;
    end else begin
      step_c   = ADDR_W'(1) << shamt;
      span_off = span_m1 << shamt;
    end
    start_c = end_i - span_off;
    case (wcode_i)
      2'd1:    misalign_o = end_i[0];
      2'd2:    misalign_o = |end_i[1:0];
      default: misalign_o = 1'b0;
    endcase
  end

  always_comb begin
    start_d = start_q;
    addr_d  = addr_q;
    step_d  = step_q;
    end_d   = end_q;
    wrap_d  = wrap_q;
    if (load_i) begin
      start_d = start_c;
      addr_d  = start_c;
      step_d  = step_c;
      end_d   = end_i;
      wrap_d  = wrap_en_i;
    end else if (step_i) begin
      if (wrap_q && wrap_pt_i) addr_d = start_q;
      else                     addr_d = addr_q + step_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      addr_q  <= '0;
      step_q  <= '0;
      end_q   <= '0;
      wrap_q  <= 1'b0;
    end else begin
      if (load_i) begin
        start_q <= start_d;
        step_q  <= step_d;
        end_q   <= end_d;
        wrap_q  <= wrap_d;
      end
      if (load_i || step_i) addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  // R4: a side with a zero stride never moves between loads
  a_r4_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && step_q == '0) |=> (addr_q == $past(addr_q)));
  // R5: a wrapping side stays inside its burst window
  a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && end_q >= start_q) |-> (addr_q >= start_q && addr_q <= end_q));
endmodule

// File: rtl/lkd_dma_chan.sv
`timescale 1ns/1ps
module lkd_dma_chan
  import lkd_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  start_ptr_i,
  input  logic               set_valid_i,
  input  logic               trig_i,
  input  logic [BURST_W-1:0] ch_burst_log2_i,
  input  logic               ch_src_wrap_i,
  input  logic               ch_dst_wrap_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [1:0]         mem_size_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic               mem_gnt_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic               flag_a_o,
  output logic               flag_b_o,
  output logic               err_o
);
  localparam int NSIDE = 2;

  lkd_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, send_q, send_d, dend_q, dend_d, next_q, next_d;
  logic [WORD_W-1:0] cfg_q, cfg_d, data_q, data_d;
  logic [1:0]        widx_q, widx_d;
  logic              trig_q, trig_d, fa_q, fa_d, fb_q, fb_d, err_q, err_d;
  logic              load, step, is_last, burst_end, bad;
  logic              cfg_unused;

  logic [ADDR_W-1:0] side_end  [NSIDE];
  logic [1:0]        side_inc  [NSIDE];
  logic              side_wen  [NSIDE];
  logic [ADDR_W-1:0] side_addr [NSIDE];
  logic              side_mis  [NSIDE];

  assign side_end[0] = send_q;
  assign side_end[1] = dend_q;
  assign side_inc[0] = cfg_q[SINC_LO +: 2];
  assign side_inc[1] = cfg_q[DINC_LO +: 2];
  assign side_wen[0] = ch_src_wrap_i;
  assign side_wen[1] = ch_dst_wrap_i;
  assign cfg_unused  = ^{cfg_q[31:26], cfg_q[11:10], cfg_q[7:6]};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    lkd_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_W(BURST_W)) u_ag (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .step_i       (step),
      .wrap_pt_i    (burst_end),
      .end_i        (side_end[g]),
      .inc_i        (side_inc[g]),
      .wcode_i      (cfg_q[W_LO +: 2]),
      .wrap_en_i    (side_wen[g]),
      .burst_log2_i (ch_burst_log2_i),
      .cnt_m1_i     (cfg_q[CNT_LO +: CNT_W]),
      .addr_o       (side_addr[g]),
      .misalign_o   (side_mis[g])
    );
  end

  lkd_beat_cnt #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (load),
    .inc_i        (step),
    .last_m1_i    (cfg_q[CNT_LO +: CNT_W]),
    .burst_log2_i (ch_burst_log2_i),
    .is_last_o    (is_last),
    .burst_end_o  (burst_end)
  );

  assign bad = (cfg_q[W_LO +: 2] == 2'd3) | side_mis[0] | side_mis[1];

  always_comb begin
    state_d = state_q;  ptr_d  = ptr_q;  widx_d = widx_q;
    cfg_d   = cfg_q;    send_d = send_q; dend_d = dend_q; next_d = next_q;
    data_d  = data_q;   trig_d = trig_q;
    fa_d    = fa_q;     fb_d   = fb_q;   err_d  = err_q;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    load       = 1'b0;
    step       = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        ptr_d   = start_ptr_i;
        widx_d  = '0;
        fa_d    = 1'b0;
        fb_d    = 1'b0;
        err_d   = 1'b0;
        trig_d  = 1'b0;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + ADDR_W'({widx_q, 2'b00});
        if (mem_gnt_i) begin
          widx_d = widx_q + 2'd1;
          case (widx_q)
            2'd0: begin
              cfg_d = mem_rdata_i;
              if (mem_rdata_i[B_SWTRIG]) trig_d = 1'b1;
            end
            2'd1:    send_d = mem_rdata_i[ADDR_W-1:0];
            2'd2:    dend_d = mem_rdata_i[ADDR_W-1:0];
            default: begin
              next_d  = mem_rdata_i[ADDR_W-1:0];
              state_d = ST_PREP;
            end
          endcase
        end
      end
      ST_PREP: begin
        load = 1'b1;
        if (bad) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (!cfg_q[B_VALID]) state_d = ST_STALL;
        else                          state_d = ST_ARM;
      end
      ST_STALL: if (set_valid_i) begin
        cfg_d[B_VALID] = 1'b1;
        state_d        = ST_ARM;
      end
      ST_ARM: if (trig_q) state_d = ST_RD;
      ST_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = side_addr[0];
        if (mem_gnt_i) begin
          data_d  = mem_rdata_i;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = side_addr[1];
        if (mem_gnt_i) begin
          step = 1'b1;
          if (is_last) begin
            if (cfg_q[B_FLAGA])  fa_d   = 1'b1;
            if (cfg_q[B_FLAGB])  fb_d   = 1'b1;
            if (cfg_q[B_CLRTRG]) trig_d = 1'b0;
            if (cfg_q[B_RELOAD] && next_q != '0) begin
              ptr_d   = next_q;
              widx_d  = '0;
              state_d = ST_FETCH;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            state_d = ST_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (trig_i && state_q != ST_IDLE) trig_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;  widx_q <= '0;
      cfg_q   <= '0;  send_q <= '0; dend_q <= '0; next_q <= '0;
      data_q  <= '0;  trig_q <= 1'b0;
      fa_q    <= 1'b0; fb_q  <= 1'b0; err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;   widx_q <= widx_d;
      cfg_q   <= cfg_d;   send_q <= send_d; dend_q <= dend_d; next_q <= next_d;
      trig_q  <= trig_d;
      fa_q    <= fa_d;    fb_q   <= fb_d;   err_q  <= err_d;
      if (state_q == ST_RD && mem_gnt_i) data_q <= data_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign flag_a_o    = fa_q;
  assign flag_b_o    = fb_q;
  assign err_o       = err_q;
  assign mem_size_o  = cfg_q[W_LO +: 2];
  assign mem_wdata_o = data_q;

  // R7: a stalled descriptor makes no memory access
  a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STALL) |-> !mem_req_o);
  // R12: the port is only used while the channel is busy
  a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);
  // R11: a raised error leaves the channel idle
  a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);
  // R9: completion flags hold until a new start is accepted
  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b_o && !(start_i && !busy_o)) |=> flag_b_o);
  // R8: no data moves without a pending trigger
  a_r8_trig_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && !trig_q) |=> !mem_req_o);
endmodule

// File: tb/sim_lkd_dma_chan.sv
`timescale 1ns/1ps
module sim_lkd_dma_chan;
  logic        clk, rst_n;
  logic        start_i, set_valid_i, trig_i;
  logic [31:0] start_ptr_i;
  logic [3:0]  burst_log2;
  logic        src_wrap, dst_wrap;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        busy, fla, flb, err;

  int checks, errors, wr_cnt, cyc;
  logic [7:0] lfsr;
  logic [7:0] mem  [1024];
  logic [7:0] expm [1024];

  lkd_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ptr_i(start_ptr_i),
    .set_valid_i(set_valid_i), .trig_i(trig_i), .ch_burst_log2_i(burst_log2),
    .ch_src_wrap_i(src_wrap), .ch_dst_wrap_i(dst_wrap),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .flag_a_o(fla), .flag_b_o(flb),
    .err_o(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [9:0] ma;
  assign ma        = mem_addr[9:0];
  assign mem_gnt   = mem_req && (lfsr[1:0] != 2'b00);
  assign mem_rdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h5a;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cyc <= cyc + 1;
    if (rst_n && mem_req && mem_we && mem_gnt) begin
      wr_cnt <= wr_cnt + 1;
      for (int b = 0; b < (1 << mem_size); b++)
        mem[ma + 10'(b)] <= mem_wdata[8*b +: 8];
    end
  end

  // R3 field layout: {w[1:0], si[1:0], di[1:0], cnt-1[9:0], swrap, dwrap, 2'b0, burst_log2[3:0]}
  localparam int NV = 7;
  localparam logic [23:0] VECS [NV] = '{
    {2'd2, 2'd1, 2'd1, 10'd7, 1'b0, 1'b0, 2'b00, 4'd0},
    {2'd0, 2'd1, 2'd1, 10'd4, 1'b0, 1'b0, 2'b00, 4'd0},
    {2'd1, 2'd2, 2'd1, 10'd3, 1'b0, 1'b0, 2'b00, 4'd0},
    {2'd2, 2'd0, 2'd1, 10'd2, 1'b0, 1'b0, 2'b00, 4'd0},
    {2'd0, 2'd1, 2'd3, 10'd3, 1'b0, 1'b0, 2'b00, 4'd0},
    {2'd2, 2'd1, 2'd1, 10'd7, 1'b1, 1'b0, 2'b00, 4'd2},
    {2'd1, 2'd1, 2'd1, 10'd5, 1'b0, 1'b1, 2'b00, 4'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mkcfg(input bit v, rl, sw, cl, fa, fb,
                                        input int w, si, di, cnt);
    return {6'd0, 10'(cnt - 1), 2'(di), 2'(si), 2'd0, 2'(w), 2'd0,
            fb, fa, cl, sw, rl, v};
  endfunction

  function automatic int end_of(input int st, w, inc, span);
    if (inc == 0) return st;
    return st + (1 << w) * (span - 1) * (1 << (inc - 1));
  endfunction

  task automatic put_word(input int a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      mem[10'(a + b)]  = d[8*b +: 8];
      expm[10'(a + b)] = d[8*b +: 8];
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = (i >= 256 && i < 512) ? 8'(i * 7 + seed) : 8'hEE;
      expm[i] = mem[i];
    end
  endtask

  task automatic put_desc(input int da, input logic [31:0] c, input int ss, ds,
                          input int nxt, input bit swr, dwr, input int bn);
    int w, si, di, cnt;
    w   = int'(c[9:8]);  si = int'(c[13:12]); di = int'(c[15:14]);
    cnt = int'(c[25:16]) + 1;
    put_word(da,      c);
    put_word(da + 4,  end_of(ss, w, si, swr ? (1 << bn) : cnt));
    put_word(da + 8,  end_of(ds, w, di, dwr ? (1 << bn) : cnt));
    put_word(da + 12, nxt);
  endtask

  task automatic model(input logic [31:0] c, input int ss, ds,
                       input bit swr, dwr, input int bn);
    int w, si, di, cnt, sst, dst, so, dof;
    w   = int'(c[9:8]);  si = int'(c[13:12]); di = int'(c[15:14]);
    cnt = int'(c[25:16]) + 1;
    sst = (si == 0) ? 0 : (1 << w) << (si - 1);
    dst = (di == 0) ? 0 : (1 << w) << (di - 1);
    for (int i = 0; i < cnt; i++) begin
      so  = sst * (swr ? (i % (1 << bn)) : i);
      dof = dst * (dwr ? (i % (1 << bn)) : i);
      for (int b = 0; b < (1 << w); b++)
        expm[10'(ds + dof + b)] = expm[10'(ss + so + b)];
    end
  endtask

  function automatic int diffs();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) n++;
    return n;
  endfunction

  task automatic go(input int ptr);
    @(negedge clk); start_i = 1'b1; start_ptr_i = ptr;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_valid();
    @(negedge clk); set_valid_i = 1'b1;
    @(negedge clk); set_valid_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; wr_cnt = 0; cyc = 0;
    rst_n = 1'b0; start_i = 1'b0; set_valid_i = 1'b0; trig_i = 1'b0;
    start_ptr_i = '0; burst_log2 = '0; src_wrap = 1'b0; dst_wrap = 1'b0;
    fill(0);
    repeat (3) @(negedge clk);
    check(!busy && !fla && !flb && !err && !mem_req, "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !fla && !flb && !err && !mem_req, "R1 after release", int'(busy), 0);

    // table walk: R2 R3 R4 R5 R6 R9 R12
    for (int v = 0; v < NV; v++) begin
      logic [31:0] c;
      logic [23:0] e;
      e = VECS[v];
      fill(v);
      burst_log2 = e[3:0]; src_wrap = e[7]; dst_wrap = e[6];
      c = mkcfg(1, 0, 1, 1, 0, 1, int'(e[23:22]), int'(e[21:20]),
                int'(e[19:18]), int'(e[17:8]) + 1);
      put_desc(0, c, 32'h100, 32'h200, 0, e[7], e[6], int'(e[3:0]));
      model(c, 32'h100, 32'h200, e[7], e[6], int'(e[3:0]));
      go(0);
      check(busy, "R12 busy after start", int'(busy), 1);
      wait_idle();
      check(diffs() == 0, "R4 R5 R6 copy result", diffs(), 0);
      check(flb && !fla && !err, "R9 flags after vector", int'({fla, flb, err}), 2);
    end
    burst_log2 = '0; src_wrap = 1'b0; dst_wrap = 1'b0;

    // R11 misaligned source end
    fill(20);
    put_desc(0, mkcfg(1, 0, 1, 1, 0, 1, 2, 1, 1, 4), 32'h102, 32'h200, 0, 0, 0, 0);
    wr_cnt = 0;
    go(0); wait_idle();
    check(err && !busy && wr_cnt == 0, "R11 misaligned error", wr_cnt, 0);
    check(diffs() == 0, "R11 no data moved", diffs(), 0);

    // R11 width code 3
    fill(21);
    put_desc(0, mkcfg(1, 0, 1, 1, 0, 1, 3, 1, 1, 2), 32'h100, 32'h200, 0, 0, 0, 0);
    wr_cnt = 0;
    go(0); wait_idle();
    check(err && wr_cnt == 0, "R11 width code 3", int'(err), 1);
    go(0);
    check(!err, "R11 err cleared by start", int'(err), 0);
    wait_idle();

    // R7 stall on clear valid bit
    fill(22);
    begin
      logic [31:0] c;
      c = mkcfg(0, 0, 1, 1, 1, 0, 1, 1, 1, 3);
      put_desc(0, c, 32'h100, 32'h200, 0, 0, 0, 0);
      wr_cnt = 0;
      go(0);
      repeat (30) @(negedge clk);
      check(busy && wr_cnt == 0, "R7 held while invalid", wr_cnt, 0);
      pulse_valid(); wait_idle();
      model(c, 32'h100, 32'h200, 0, 0, 0);
      check(diffs() == 0 && fla && !flb, "R7 R9 runs after valid", diffs(), 0);
    end

    // R8 hardware trigger
    fill(23);
    begin
      logic [31:0] c;
      c = mkcfg(1, 0, 0, 1, 0, 1, 0, 1, 1, 4);
      put_desc(0, c, 32'h100, 32'h200, 0, 0, 0, 0);
      wr_cnt = 0;
      go(0);
      repeat (30) @(negedge clk);
      check(busy && wr_cnt == 0, "R8 waits for trigger", wr_cnt, 0);
      pulse_trig(); wait_idle();
      model(c, 32'h100, 32'h200, 0, 0, 0);
      check(diffs() == 0, "R8 runs after trigger", diffs(), 0);
    end

    // R10 reload chain
    fill(24);
    begin
      logic [31:0] c0, c1;
      c0 = mkcfg(1, 1, 1, 1, 0, 1, 2, 1, 1, 4);
      c1 = mkcfg(1, 0, 1, 1, 1, 0, 1, 1, 1, 3);
      put_desc(0,  c0, 32'h100, 32'h200, 32'h10, 0, 0, 0);
      put_desc(16, c1, 32'h140, 32'h280, 0, 0, 0, 0);
      model(c0, 32'h100, 32'h200, 0, 0, 0);
      model(c1, 32'h140, 32'h280, 0, 0, 0);
      go(0); wait_idle();
      check(diffs() == 0, "R10 linked chain copied", diffs(), 0);
      check(fla && flb, "R9 R10 flags from both links", int'({fla, flb}), 3);
    end

    // R10 reload bit clear ends at first descriptor
    fill(25);
    begin
      logic [31:0] c0, c1;
      c0 = mkcfg(1, 0, 1, 1, 0, 1, 2, 1, 1, 2);
      c1 = mkcfg(1, 0, 1, 1, 1, 0, 1, 1, 1, 3);
      put_desc(0,  c0, 32'h100, 32'h200, 32'h10, 0, 0, 0);
      put_desc(16, c1, 32'h140, 32'h280, 0, 0, 0, 0);
      model(c0, 32'h100, 32'h200, 0, 0, 0);
      go(0); wait_idle();
      check(diffs() == 0 && !fla, "R10 no reload without bit", diffs(), 0);
    end

    // R7 R10 reload into an invalid descriptor
    fill(26);
    begin
      logic [31:0] c0, c1;
      c0 = mkcfg(1, 1, 1, 1, 0, 1, 2, 1, 1, 2);
      c1 = mkcfg(0, 0, 1, 1, 1, 0, 0, 1, 1, 5);
      put_desc(0,  c0, 32'h100, 32'h200, 32'h10, 0, 0, 0);
      put_desc(16, c1, 32'h140, 32'h280, 0, 0, 0, 0);
      model(c0, 32'h100, 32'h200, 0, 0, 0);
      wr_cnt = 0;
      go(0);
      for (int i = 0; i < 400 && wr_cnt < 2; i++) @(negedge clk);
      repeat (40) @(negedge clk);
      check(busy && diffs() == 0, "R7 R10 stalled on reloaded link", diffs(), 0);
      pulse_valid(); wait_idle();
      model(c1, 32'h140, 32'h280, 0, 0, 0);
      check(diffs() == 0 && fla && !busy, "R10 reloaded link finished", diffs(), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule